// File: doc/BRIEF.md
# Dual Drive Select and Motor Timeout

This block hands out the select lines of two small flexible-disk drives (four in the quad option). Every drive has two independent selects: one enables its read/write electronics, the other its motion-control (head stepping) electronics. A host issues one command per cycle, addressed to one drive. The command claims the read/write select, claims the motion select and fires a step pulse, or releases selects. The block rejects any claim that would give two drives the same kind of select. One drive can therefore seek while another transfers data.

Each drive has its own spindle motor output. The head counts as loaded whenever the motor runs. Any accepted command starts a stopped motor and holds a busy flag through a spin-up period that software sets. Every accepted command to a drive restarts that drive's idle timer. When the timer runs out after `IDLE_SEC` seconds of `CLK_HZ` clock cycles with no accepted command, the motor stops and the drive loses any select it holds.

With `QUAD_MODE` set, the drive index is two bits wide. Each of the two held select codes then passes through a 2-to-4 decoder to give four read/write lines and four motion lines.

Top module: `dual_drive_sel`

## Requirements
- R1: After reset, all selects, motor, busy, step and direction outputs are low, and `cmd_err` is low.
- R2: A read/write claim (`cmd_op`=1) to drive d is rejected while another drive holds the read/write select. Otherwise drive d gets the read/write select from the next cycle on.
- R3: A step command (`cmd_op`=2) is rejected while another drive holds the motion select, or while any step pulse is in progress. Otherwise drive d gets the motion select.
- R4: One drive may hold the read/write select while a different drive holds the motion select, both at the same time.
- R5: An accepted command to a drive whose motor is off raises that drive's `motor_on` after the clock edge. `busy` is then high for exactly `spinup_len` cycles. A command to a running motor does not restart the spin-up count.
- R6: `motor_on` stays high for exactly `CLK_HZ*IDLE_SEC` cycles after the last accepted command to that drive, and each accepted command restarts that count. When the count runs out, the motor drops and the drive loses both of its selects at the same edge.
- R7: An accepted step command raises `step[d]` for exactly `STEP_CYC` cycles. `dir[d]` takes `cmd_dir` (1 = inward) and holds it until the next accepted step to drive d.
- R8: A release-all command (`cmd_op`=0) drops both selects drive d holds. A park command (`cmd_op`=3) drops only its motion select. Either one is rejected while drive d's step pulse is in progress.
- R9: A rejected command raises `cmd_err` for the single next cycle. It changes no select, step, direction, motor or idle timer.
- R10: In quad mode, the held read/write code and the held motion code each decode to one-hot lines, where line i means drive index i. At most one line of each kind is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 release all, 1 read/write claim, 2 step, 3 park head |
| cmd_drive | input | IDX_W | Target drive index |
| cmd_dir | input | 1 | Step direction for a step command, 1 = inward |
| spinup_len | input | SPIN_W | Spin-up busy length in cycles |
| cmd_err | output | 1 | Previous command was rejected |
| rw_sel | output | N_DRV | Read/write electronics select per drive |
| mot_sel | output | N_DRV | Motion-control select per drive |
| motor_on | output | N_DRV | Spindle motor (and head load) per drive |
| busy | output | N_DRV | Motor spinning up |
| step | output | N_DRV | Step pulse per drive |
| dir | output | N_DRV | Step direction per drive |

## Verification
The bound checker checks on every cycle that the decoded read/write and motion lines stay one-hot-or-empty. It also checks that a drive holding any select has its motor running, that a rejected command lets no select newly rise, and that motors and step pulses only rise right after a command. The exact lengths of spin-up, step pulses and the idle timeout are shown only by the bench scenarios. So are the restart of a timer by a later command, the simultaneous seek-plus-transfer pairing, and the choice between accept and reject across sweeps of every operation, drive and direction. In those sweeps the bench compares all outputs on every cycle with a model built from the requirements.

// File: rtl/fdsel_pkg.sv
package fdsel_pkg;
  typedef enum logic [1:0] {
    OP_FREE = 2'd0,
    OP_XFER = 2'd1,
    OP_STEP = 2'd2,
    OP_PARK = 2'd3
  } drv_op_e;
endpackage

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int IDX_W = 1,
  parameter int N_OUT = 2
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N_OUT-1:0] lines
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_line
    assign lines[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/spindle_timer.sv
module spindle_timer #(
  parameter int unsigned TMO_CYC = 100,
  parameter int          SPIN_W  = 8,
  localparam int         TMO_W   = $clog2(TMO_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [SPIN_W-1:0] spin_len,
  output logic              motor_on,
  output logic              busy,
  output logic              expire
);
  logic              on_q, on_d;
  logic [TMO_W-1:0]  idle_q, idle_d;
  logic [SPIN_W-1:0] spin_q, spin_d;

  assign expire = on_q && (idle_q == '0) && !kick;

  always_comb begin
    on_d   = on_q;
    idle_d = idle_q;
    spin_d = spin_q;
    if (kick) begin
      idle_d = TMO_W'(TMO_CYC - 1);
      if (!on_q) begin
        on_d   = 1'b1;
        spin_d = spin_len;
      end else if (spin_q != '0) begin
        spin_d = spin_q - 1'b1;
      end
    end else if (on_q) begin
      if (idle_q == '0) begin
        on_d   = 1'b0;
        spin_d = '0;
      end else begin
        idle_d = idle_q - 1'b1;
        if (spin_q != '0) spin_d = spin_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      idle_q <= '0;
      spin_q <= '0;
    end else begin
      on_q   <= on_d;
      idle_q <= idle_d;
      spin_q <= spin_d;
    end
  end

  assign motor_on = on_q;
  assign busy     = on_q && (spin_q != '0);
endmodule

// File: rtl/step_pulse.sv
module step_pulse #(
  parameter int unsigned STEP_CYC = 4,
  localparam int         CW       = $clog2(STEP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = CW'(STEP_CYC);
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/sel_arbiter.sv
module sel_arbiter import fdsel_pkg::*; #(
  parameter int N_DRV = 2,
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_drive,
  input  logic             cmd_dir,
  input  logic             step_active,
  input  logic [N_DRV-1:0] expire,
  output logic             accept,
  output logic             step_load,
  output logic             rw_v,
  output logic [IDX_W-1:0] rw_i,
  output logic             mo_v,
  output logic [IDX_W-1:0] mo_i,
  output logic [N_DRV-1:0] dir_q,
  output logic             err_q
);
  drv_op_e          op;
  logic             ok;
  logic             rw_other, mo_other, mo_mine_moving;
  logic             rw_v_d, mo_v_d;
  logic [IDX_W-1:0] rw_i_d, mo_i_d;

  assign op             = drv_op_e'(cmd_op);
  assign rw_other       = rw_v && (rw_i != cmd_drive);
  assign mo_other       = mo_v && (mo_i != cmd_drive);
  assign mo_mine_moving = mo_v && (mo_i == cmd_drive) && step_active;

  always_comb begin
    unique case (op)
      OP_XFER: ok = !rw_other;
      OP_STEP: ok = !mo_other && !step_active;
      default: ok = !mo_mine_moving;
    endcase
  end

  assign accept    = cmd_valid && ok;
  assign step_load = accept && (op == OP_STEP);

  always_comb begin
    rw_v_d = rw_v;
    rw_i_d = rw_i;
    mo_v_d = mo_v;
    mo_i_d = mo_i;
    if (rw_v && expire[rw_i]) rw_v_d = 1'b0;
    if (mo_v && expire[mo_i]) mo_v_d = 1'b0;
    if (accept) begin
      unique case (op)
        OP_XFER: begin
          rw_v_d = 1'b1;
          rw_i_d = cmd_drive;
        end
        OP_STEP: begin
          mo_v_d = 1'b1;
          mo_i_d = cmd_drive;
        end
        OP_FREE: begin
          if (rw_v && rw_i == cmd_drive) rw_v_d = 1'b0;
          if (mo_v && mo_i == cmd_drive) mo_v_d = 1'b0;
        end
        OP_PARK: begin
          if (mo_v && mo_i == cmd_drive) mo_v_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_v  <= 1'b0;
      rw_i  <= '0;
      mo_v  <= 1'b0;
      mo_i  <= '0;
      err_q <= 1'b0;
    end else begin
      rw_v  <= rw_v_d;
      rw_i  <= rw_i_d;
      mo_v  <= mo_v_d;
      mo_i  <= mo_i_d;
      err_q <= cmd_valid && !ok;
    end
  end

  for (genvar i = 0; i < N_DRV; i++) begin : g_dir
    logic dir_en;
    assign dir_en = step_load && (cmd_drive == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q[i] <= 1'b0;
      else if (dir_en) dir_q[i] <= cmd_dir;
    end
  end
endmodule

// File: rtl/dual_drive_sel.sv
module dual_drive_sel #(
  parameter bit          QUAD_MODE = 1'b0,
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned IDLE_SEC  = 2,
  parameter int unsigned STEP_CYC  = 100,
  parameter int          SPIN_W    = 24,
  localparam int         N_DRV     = QUAD_MODE ? 4 : 2,
  localparam int         IDX_W     = QUAD_MODE ? 2 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_drive,
  input  logic              cmd_dir,
  input  logic [SPIN_W-1:0] spinup_len,
  output logic              cmd_err,
  output logic [N_DRV-1:0]  rw_sel,
  output logic [N_DRV-1:0]  mot_sel,
  output logic [N_DRV-1:0]  motor_on,
  output logic [N_DRV-1:0]  busy,
  output logic [N_DRV-1:0]  step,
  output logic [N_DRV-1:0]  dir
);
  localparam int unsigned TMO_CYC = CLK_HZ * IDLE_SEC;

  logic [1:0]       rst_pipe;
  logic             rst_sn;
  logic             accept, step_load, step_active;
  logic             rw_v, mo_v;
  logic [IDX_W-1:0] rw_i, mo_i;
  logic [N_DRV-1:0] expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  sel_arbiter #(.N_DRV(N_DRV), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_sn),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_drive(cmd_drive), .cmd_dir(cmd_dir),
    .step_active(step_active), .expire(expire),
    .accept(accept), .step_load(step_load),
    .rw_v(rw_v), .rw_i(rw_i), .mo_v(mo_v), .mo_i(mo_i),
    .dir_q(dir), .err_q(cmd_err)
  );

  step_pulse #(.STEP_CYC(STEP_CYC)) u_step (
    .clk(clk), .rst_n(rst_sn), .load(step_load), .active(step_active)
  );

  sel_decode #(.IDX_W(IDX_W), .N_OUT(N_DRV)) u_rw_dec (
    .en(rw_v), .idx(rw_i), .lines(rw_sel)
  );

  sel_decode #(.IDX_W(IDX_W), .N_OUT(N_DRV)) u_mo_dec (
    .en(mo_v), .idx(mo_i), .lines(mot_sel)
  );

  for (genvar i = 0; i < N_DRV; i++) begin : g_drv
    logic kick;
    assign kick    = accept && (cmd_drive == IDX_W'(i));
    assign step[i] = step_active && mot_sel[i];
    spindle_timer #(.TMO_CYC(TMO_CYC), .SPIN_W(SPIN_W)) u_spin (
      .clk(clk), .rst_n(rst_sn), .kick(kick), .spin_len(spinup_len),
      .motor_on(motor_on[i]), .busy(busy[i]), .expire(expire[i])
    );
  end
endmodule

// File: rtl/dual_drive_sel_chk.sv
module dual_drive_sel_chk #(
  parameter int N = 2,
  parameter int W = 1
) (
  input logic         clk,
  input logic         rst_sn,
  input logic         cmd_valid,
  input logic [1:0]   cmd_op,
  input logic [W-1:0] cmd_drive,
  input logic         cmd_err,
  input logic [N-1:0] rw_sel,
  input logic [N-1:0] mot_sel,
  input logic [N-1:0] motor_on,
  input logic [N-1:0] step
);
  assert_rw_onehot_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(rw_sel));

  assert_mot_onehot_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(mot_sel));

  assert_step_cause_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    ((step & ~$past(step)) != '0) |-> ($past(cmd_valid) && $past(cmd_op) == 2'd2));

  assert_reject_frozen_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_err |-> (((rw_sel & ~$past(rw_sel)) == '0) && ((mot_sel & ~$past(mot_sel)) == '0)));

  for (genvar i = 0; i < N; i++) begin : g_drv
    assert_motor_start_R5: assert property (@(posedge clk) disable iff (!rst_sn)
      $rose(motor_on[i]) |-> ($past(cmd_valid) && $past(cmd_drive) == W'(i)));

    assert_sel_needs_motor_R6: assert property (@(posedge clk) disable iff (!rst_sn)
      (rw_sel[i] || mot_sel[i]) |-> motor_on[i]);
  end
endmodule

bind dual_drive_sel dual_drive_sel_chk #(.N(N_DRV), .W(IDX_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_drive(cmd_drive), .cmd_err(cmd_err), .rw_sel(rw_sel), .mot_sel(mot_sel),
  .motor_on(motor_on), .step(step)
);

// File: tb/sim_dual_drive_sel.sv
module sim_dual_drive_sel;
  localparam int ND   = 4;
  localparam int TMO  = 40;
  localparam int STPC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_drive = 2'd0;
  logic       cmd_dir = 1'b0;
  logic [3:0] spinup_len = 4'd5;
  logic          cmd_err;
  logic [ND-1:0] rw_sel, mot_sel, motor_on, busy, step, dir;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit live  = 1'b0;

  // model state, derived from the requirements
  bit m_rwv, m_mov, m_err;
  int m_rwi, m_moi, m_stp;
  bit m_on [ND];
  int m_idle [ND];
  int m_spin [ND];
  bit m_dir [ND];

  dual_drive_sel #(.QUAD_MODE(1'b1), .CLK_HZ(20), .IDLE_SEC(2), .STEP_CYC(STPC), .SPIN_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_drive(cmd_drive),
    .cmd_dir(cmd_dir), .spinup_len(spinup_len), .cmd_err(cmd_err), .rw_sel(rw_sel),
    .mot_sel(mot_sel), .motor_on(motor_on), .busy(busy), .step(step), .dir(dir)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rwv = 0; m_mov = 0; m_err = 0; m_rwi = 0; m_moi = 0; m_stp = 0;
      for (int i = 0; i < ND; i++) begin
        m_on[i] = 0; m_idle[i] = 0; m_spin[i] = 0; m_dir[i] = 0;
      end
    end else begin
      int d;
      bit ok, acc, kick;
      bit ex [ND];
      d = int'(cmd_drive);
      case (cmd_op)
        2'd1:    ok = !(m_rwv && m_rwi != d);
        2'd2:    ok = !(m_mov && m_moi != d) && (m_stp == 0);
        default: ok = !(m_mov && m_moi == d && m_stp > 0);
      endcase
      acc   = cmd_valid && ok;
      m_err = cmd_valid && !ok;
      for (int i = 0; i < ND; i++) begin
        kick  = acc && (d == i);
        ex[i] = m_on[i] && (m_idle[i] == 0) && !kick;
        if (kick) begin
          if (!m_on[i]) begin m_on[i] = 1; m_spin[i] = int'(spinup_len); end
          else if (m_spin[i] > 0) m_spin[i]--;
          m_idle[i] = TMO - 1;
        end else if (m_on[i]) begin
          if (ex[i]) begin m_on[i] = 0; m_spin[i] = 0; end
          else begin m_idle[i]--; if (m_spin[i] > 0) m_spin[i]--; end
        end
      end
      if (m_rwv && ex[m_rwi]) m_rwv = 0;
      if (m_mov && ex[m_moi]) m_mov = 0;
      if (acc && cmd_op == 2'd2) begin m_stp = STPC; m_dir[d] = cmd_dir; end
      else if (m_stp > 0) m_stp--;
      if (acc) begin
        case (cmd_op)
          2'd1: begin m_rwv = 1; m_rwi = d; end
          2'd2: begin m_mov = 1; m_moi = d; end
          2'd0: begin
            if (m_rwv && m_rwi == d) m_rwv = 0;
            if (m_mov && m_moi == d) m_mov = 0;
          end
          default: if (m_mov && m_moi == d) m_mov = 0;
        endcase
      end
    end
  end

  // compare every output with the model away from the active edge
  always @(negedge clk) begin
    if (live) begin
      logic [ND-1:0] e_rw, e_mo, e_on, e_bs, e_st, e_dr;
      e_rw = '0; e_mo = '0; e_on = '0; e_bs = '0; e_st = '0; e_dr = '0;
      if (m_rwv) e_rw[m_rwi] = 1'b1;
      if (m_mov) e_mo[m_moi] = 1'b1;
      if (m_mov && m_stp > 0) e_st[m_moi] = 1'b1;
      for (int i = 0; i < ND; i++) begin
        e_on[i] = m_on[i];
        e_bs[i] = m_on[i] && (m_spin[i] > 0);
        e_dr[i] = m_dir[i];
      end
      chk(rw_sel == e_rw, "R2 R10 rw_sel", 32'(rw_sel), 32'(e_rw));
      chk(mot_sel == e_mo, "R3 R8 mot_sel", 32'(mot_sel), 32'(e_mo));
      chk(motor_on == e_on, "R6 motor_on", 32'(motor_on), 32'(e_on));
      chk(busy == e_bs, "R5 busy", 32'(busy), 32'(e_bs));
      chk(step == e_st, "R7 step", 32'(step), 32'(e_st));
      chk(dir == e_dr, "R7 dir", 32'(dir), 32'(e_dr));
      chk(cmd_err == m_err, "R9 cmd_err", 32'(cmd_err), 32'(m_err));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic issue(input int op, input int d, input bit dr, input int gap);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_drive = 2'(d); cmd_dir = dr;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    chk({rw_sel, mot_sel, motor_on, busy, step, dir} == '0 && !cmd_err, "R1 reset outputs",
        32'({rw_sel, mot_sel, motor_on, busy, step}), 32'h0);
    live = 1'b1;

    // R4: transfer on drive 0 while drive 1 seeks
    issue(1, 0, 0, 0);
    issue(2, 1, 1, 0);
    chk(rw_sel == 4'b0001 && mot_sel == 4'b0010, "R4 overlap",
        32'({rw_sel, mot_sel}), 32'h12);
    // R3: a second step elsewhere is refused; R9 error next cycle
    issue(2, 2, 0, 0);
    chk(cmd_err == 1'b1 && mot_sel == 4'b0010, "R3 R9 second step refused",
        32'({cmd_err, mot_sel}), 32'h12);
    idle(60);
    // R6: all motors stopped after the idle period
    chk(motor_on == '0 && rw_sel == '0, "R6 timeout clears", 32'({motor_on, rw_sel}), 32'h0);

    // sweeps over operation, drive, direction and gap
    for (int op = 0; op < 4; op++)
      for (int d = 0; d < ND; d++)
        for (int dr = 0; dr < 2; dr++)
          for (int g = 0; g < 3; g++)
            issue(op, d, dr[0], g);
    @(negedge clk) spinup_len = 4'd0;
    for (int d = 0; d < ND; d++)
      for (int op = 3; op >= 0; op--)
        for (int g = 0; g < 4; g++)
          issue(op, (d + g) % ND, g[0], g);
    idle(50);
    @(negedge clk) spinup_len = 4'd15;
    for (int g = 0; g < 5; g++)
      for (int d = 0; d < ND; d++)
        for (int op = 0; op < 4; op++)
          issue((op + d) % 4, d, op[0], g % 3);
    idle(50);
    chk(motor_on == '0, "R6 final idle", 32'(motor_on), 32'h0);

    live = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule